// File: doc/BRIEF.md
# UART Automatic Modem Handshake Controller

This block performs automatic hardware handshaking for a single UART channel. On the transmit side it watches the remote clear-to-send line. When the remote end raises that line, the block withdraws permission to transmit. It does this at a character boundary: a character already on the wire always finishes, including its stop bit. On the receive side it drives the local request-to-send line from the receive FIFO fill count. A pair of thresholds (a high level and a low level) gives the line hysteresis.

Two state machines do the work. The transmit gate has three states. `GATE_RUN` means sending is allowed. `GATE_DRAIN` means a stop has been requested but the current character is still finishing. `GATE_HALT` means sending is stopped. Its transitions are:
- `GATE_RUN`→`GATE_DRAIN` on a stop request while a character is in flight.
- `GATE_RUN`→`GATE_HALT` on a stop request while the line is idle, or in the same cycle as the end of a character.
- `GATE_DRAIN`→`GATE_HALT` on the character-done strobe.
- `GATE_DRAIN`→`GATE_RUN` and `GATE_HALT`→`GATE_RUN` when the request is withdrawn, or when automatic CTS is turned off.

The receive-side machine has two states, `RTS_ASSERTED` and `RTS_NEGATED`. It moves `RTS_ASSERTED`→`RTS_NEGATED` when the fill count reaches the high level. It moves back, `RTS_NEGATED`→`RTS_ASSERTED`, when the fill count falls to the low level or below. In the shallow FIFO mode the threshold pair comes from a four-entry table indexed by a 2-bit selector. In the deep mode the pair comes from two software registers. A remap bit moves both handshake functions onto the DSR/DTR pair.

Top module: `uart_hwflow`

## Requirements
- R1: After reset, `tx_permit` is 1, `cts_flag` is 0, and with automatic RTS enabled and an empty FIFO, `rts_out` is 0 (asserted).
- R2: With `auto_cts_en` at 0, `tx_permit` stays 1 whatever the handshake input does.
- R3: The handshake input (1 = stop) passes through a two-flop synchroniser. With the transmitter idle (`tx_active`=0), a change made between two rising edges moves `tx_permit` on the third rising edge after the change, and not before.
- R4: A stop request that arrives while `tx_active`=1 leaves `tx_permit` at 1 until `char_done` pulses. `tx_permit` then drops on that same edge.
- R5: When the handshake input returns to 0, `tx_permit` returns to 1 on the third rising edge after the change.
- R6: A 0→1 transition of the synchronised handshake input sets `cts_flag` on the same edge that halts transmission, but only when both `auto_cts_en` and `irq_en` are 1. Once set, the flag stays set.
- R7: A one-cycle `stat_rd` pulse clears `cts_flag` on the next edge. If a new transition arrives in the same cycle as the read, the set wins.
- R8: With `pin_remap`=1, the stop request is taken from `dsr_in` and `cts_in` is ignored. The automatic RTS level drives `dtr_out`, while `rts_out` carries `sw_rts`.
- R9: In shallow mode (`deep_mode`=0), RTS is negated (pin=1) when the fill count reaches the high level of the selected pair. It is reasserted (pin=0) when the fill count is at or below the low level. The pairs, written as (high, low) for `trig_sel` = 0,1,2,3, are (8,0), (16,7), (24,15) and (28,23).
- R10: In deep mode (`deep_mode`=1), the high level is `flow_hi` and the low level is `flow_lo`. Fill counts up to 128 are supported.
- R11: While the fill count lies strictly between the two levels, the RTS pin keeps its previous value. Each RTS change becomes visible one edge after the fill count changes.
- R12: With `auto_rts_en`=0, `rts_out` equals `sw_rts` and `dtr_out` equals `sw_dtr`, combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| auto_rts_en | input | 1 | Enable automatic RTS from FIFO level |
| auto_cts_en | input | 1 | Enable automatic transmit gating |
| irq_en | input | 1 | Allow handshake transitions to set the status flag |
| pin_remap | input | 1 | Use DSR/DTR instead of CTS/RTS |
| deep_mode | input | 1 | 1 = thresholds from registers, 0 = table |
| trig_sel | input | 2 | Table entry select for shallow mode |
| fill_count | input | 8 | Receive FIFO occupancy |
| flow_hi | input | 8 | Deep-mode negate level |
| flow_lo | input | 8 | Deep-mode reassert level |
| tx_active | input | 1 | A character is being shifted out |
| char_done | input | 1 | Strobe: stop bit of current character finished |
| stat_rd | input | 1 | Strobe: status register read |
| sw_rts | input | 1 | Software RTS pin level |
| sw_dtr | input | 1 | Software DTR pin level |
| cts_in | input | 1 | Raw CTS pin, 1 = stop |
| dsr_in | input | 1 | Raw DSR pin, 1 = stop |
| tx_permit | output | 1 | Transmitter may start or continue characters |
| rts_out | output | 1 | RTS pin, active low |
| dtr_out | output | 1 | DTR pin, active low |
| cts_flag | output | 1 | Sticky handshake-change status / interrupt |

## Verification
The bench builds the block with its default parameters: a deep FIFO of 128 entries, a shallow FIFO of 32 entries, and two synchroniser stages. The 128-entry width lets a deep-mode high level of exactly 128 be tested at the top of the count range. The 32-entry setting exercises all four derived table pairs, both one below and exactly at each edge. The two-stage synchroniser makes the exact three-edge latency of a handshake change observable, together with the coincidence of a status read and a new transition.

// File: rtl/flow_pkg.sv
package flow_pkg;
    typedef enum logic [1:0] {
        GATE_RUN   = 2'd0,
        GATE_DRAIN = 2'd1,
        GATE_HALT  = 2'd2
    } gate_state_e;

    typedef enum logic {
        RTS_ASSERTED = 1'b0,
        RTS_NEGATED  = 1'b1
    } rts_state_e;
endpackage

// File: rtl/flow_sync.sv
module flow_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level,
    output logic rise
);
    logic [STAGES:0] chain_q;

    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-1:0], din};
    end

    always_comb begin
        level = chain_q[STAGES-1];
        rise  = chain_q[STAGES-1] & ~chain_q[STAGES];
    end
endmodule

// File: rtl/flow_tx_gate.sv
module flow_tx_gate
    import flow_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic auto_en,
    input  logic stop_req,
    input  logic tx_active,
    input  logic char_done,
    output logic tx_permit
);
    gate_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (!auto_en) begin
            state_d = GATE_RUN;
        end else begin
            unique case (state_q)
                GATE_RUN: begin
                    if (stop_req) state_d = (tx_active && !char_done) ? GATE_DRAIN : GATE_HALT;
                end
                GATE_DRAIN: begin
                    if (!stop_req)     state_d = GATE_RUN;
                    else if (char_done) state_d = GATE_HALT;
                end
                GATE_HALT: begin
                    if (!stop_req) state_d = GATE_RUN;
                end
                default: state_d = GATE_RUN;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= GATE_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        tx_permit = !auto_en || (state_q != GATE_HALT);
    end

    a_r2_disabled_runs: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_en |=> state_q == GATE_RUN);
    a_r4_drain_ends_halt: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_en && state_q == GATE_DRAIN && stop_req && char_done) |=> state_q == GATE_HALT);
    a_r5_release_resumes: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != GATE_RUN && !stop_req) |=> state_q == GATE_RUN);
endmodule

// File: rtl/flow_rts_hyst.sv
module flow_rts_hyst
    import flow_pkg::*;
#(
    parameter int SHALLOW = 32,
    parameter int CNT_W   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             deep_mode,
    input  logic [1:0]       trig_sel,
    input  logic [CNT_W-1:0] fill_count,
    input  logic [CNT_W-1:0] flow_hi,
    input  logic [CNT_W-1:0] flow_lo,
    output logic             rts_level
);
    localparam int QUART = SHALLOW / 4;

    logic [CNT_W-1:0] hi_lvl, lo_lvl;
    rts_state_e state_q, state_d;

    always_comb begin
        if (deep_mode) begin
            hi_lvl = flow_hi;
            lo_lvl = flow_lo;
        end else begin
            unique case (trig_sel)
                2'd0: begin hi_lvl = CNT_W'(QUART);         lo_lvl = '0; end
                2'd1: begin hi_lvl = CNT_W'(2*QUART);       lo_lvl = CNT_W'(QUART-1); end
                2'd2: begin hi_lvl = CNT_W'(3*QUART);       lo_lvl = CNT_W'(2*QUART-1); end
                default: begin hi_lvl = CNT_W'(SHALLOW-QUART/2); lo_lvl = CNT_W'(3*QUART-1); end
            endcase
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RTS_ASSERTED: if (fill_count >= hi_lvl) state_d = RTS_NEGATED;
            RTS_NEGATED:  if (fill_count <= lo_lvl) state_d = RTS_ASSERTED;
            default:      state_d = RTS_ASSERTED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RTS_ASSERTED;
        else        state_q <= state_d;
    end

    always_comb begin
        rts_level = (state_q == RTS_NEGATED);
    end

    a_r9_negate_at_high: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_count >= hi_lvl && hi_lvl > lo_lvl) |=> rts_level);
    a_r9_assert_at_low: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_count <= lo_lvl && hi_lvl > lo_lvl) |=> !rts_level);
    a_r11_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_count > lo_lvl && fill_count < hi_lvl) |=> $stable(rts_level));
endmodule

// File: rtl/uart_hwflow.sv
module uart_hwflow #(
    parameter int DEPTH       = 128,
    parameter int SHALLOW     = 32,
    parameter int SYNC_STAGES = 2,
    localparam int CNT_W      = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             auto_rts_en,
    input  logic             auto_cts_en,
    input  logic             irq_en,
    input  logic             pin_remap,
    input  logic             deep_mode,
    input  logic [1:0]       trig_sel,
    input  logic [CNT_W-1:0] fill_count,
    input  logic [CNT_W-1:0] flow_hi,
    input  logic [CNT_W-1:0] flow_lo,
    input  logic             tx_active,
    input  logic             char_done,
    input  logic             stat_rd,
    input  logic             sw_rts,
    input  logic             sw_dtr,
    input  logic             cts_in,
    input  logic             dsr_in,
    output logic             tx_permit,
    output logic             rts_out,
    output logic             dtr_out,
    output logic             cts_flag
);
    logic hs_raw, hs_level, hs_rise, rts_level, flag_set;

    always_comb hs_raw = pin_remap ? dsr_in : cts_in;

    flow_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(hs_raw), .level(hs_level), .rise(hs_rise)
    );

    flow_tx_gate u_gate (
        .clk(clk), .rst_n(rst_n), .auto_en(auto_cts_en), .stop_req(hs_level),
        .tx_active(tx_active), .char_done(char_done), .tx_permit(tx_permit)
    );

    flow_rts_hyst #(.SHALLOW(SHALLOW), .CNT_W(CNT_W)) u_rts (
        .clk(clk), .rst_n(rst_n), .deep_mode(deep_mode), .trig_sel(trig_sel),
        .fill_count(fill_count), .flow_hi(flow_hi), .flow_lo(flow_lo),
        .rts_level(rts_level)
    );

    always_comb begin
        flag_set = hs_rise && auto_cts_en && irq_en;
        rts_out  = (auto_rts_en && !pin_remap) ? rts_level : sw_rts;
        dtr_out  = (auto_rts_en &&  pin_remap) ? rts_level : sw_dtr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)        cts_flag <= 1'b0;
        else if (flag_set) cts_flag <= 1'b1;
        else if (stat_rd)  cts_flag <= 1'b0;
    end

    a_r6_flag_sets: assert property (@(posedge clk) disable iff (!rst_n)
        flag_set |=> cts_flag);
    a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !flag_set) |=> !cts_flag);
    a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (cts_flag && !stat_rd) |=> cts_flag);
endmodule

// File: tb/uart_hwflow_bench.sv
module uart_hwflow_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic auto_rts_en = 1'b1, auto_cts_en = 1'b1, irq_en = 1'b0, pin_remap = 1'b0;
    logic deep_mode = 1'b0;
    logic [1:0] trig_sel = 2'd0;
    logic [7:0] fill_count = '0, flow_hi = 8'd100, flow_lo = 8'd40;
    logic tx_active = 1'b0, char_done = 1'b0, stat_rd = 1'b0;
    logic sw_rts = 1'b0, sw_dtr = 1'b0, cts_in = 1'b0, dsr_in = 1'b0;
    logic tx_permit, rts_out, dtr_out, cts_flag;
    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    uart_hwflow u_uart_hwflow (
        .clk(clk), .rst_n(rst_n), .auto_rts_en(auto_rts_en), .auto_cts_en(auto_cts_en),
        .irq_en(irq_en), .pin_remap(pin_remap), .deep_mode(deep_mode), .trig_sel(trig_sel),
        .fill_count(fill_count), .flow_hi(flow_hi), .flow_lo(flow_lo),
        .tx_active(tx_active), .char_done(char_done), .stat_rd(stat_rd),
        .sw_rts(sw_rts), .sw_dtr(sw_dtr), .cts_in(cts_in), .dsr_in(dsr_in),
        .tx_permit(tx_permit), .rts_out(rts_out), .dtr_out(dtr_out), .cts_flag(cts_flag)
    );

    task automatic check(string req, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear_flag();
        stat_rd = 1'b1; tick(1); stat_rd = 1'b0;
    endtask

    task automatic t_reset();
        tick(3); rst_n = 1'b1; tick(1);
        check("R1 permit", tx_permit, 1'b1);
        check("R1 flag", cts_flag, 1'b0);
        check("R1 rts", rts_out, 1'b0);
    endtask

    task automatic t_cts_disabled();
        auto_cts_en = 1'b0; cts_in = 1'b1; tick(5);
        check("R2 permit while disabled", tx_permit, 1'b1);
        cts_in = 1'b0; tick(4); auto_cts_en = 1'b1; tick(1);
    endtask

    task automatic t_idle_stop_resume();
        cts_in = 1'b1; tick(2);
        check("R3 not yet", tx_permit, 1'b1);
        tick(1);
        check("R3 halted", tx_permit, 1'b0);
        cts_in = 1'b0; tick(2);
        check("R5 not yet", tx_permit, 1'b0);
        tick(1);
        check("R5 resumed", tx_permit, 1'b1);
    endtask

    task automatic t_drain();
        tx_active = 1'b1; cts_in = 1'b1; tick(6);
        check("R4 finishing char", tx_permit, 1'b1);
        char_done = 1'b1; tick(1); char_done = 1'b0; tx_active = 1'b0;
        check("R4 halted after stop bit", tx_permit, 1'b0);
        cts_in = 1'b0; tick(3);
        check("R5 resumed after drain", tx_permit, 1'b1);
    endtask

    task automatic t_irq();
        irq_en = 1'b0; cts_in = 1'b1; tick(4);
        check("R6 masked", cts_flag, 1'b0);
        cts_in = 1'b0; tick(4);
        irq_en = 1'b1; cts_in = 1'b1; tick(2);
        check("R6 not yet", cts_flag, 1'b0);
        tick(1);
        check("R6 set", cts_flag, 1'b1);
        cts_in = 1'b0; tick(4);
        check("R6 sticky", cts_flag, 1'b1);
        clear_flag();
        check("R7 cleared", cts_flag, 1'b0);
        cts_in = 1'b1; tick(2); stat_rd = 1'b1; tick(1); stat_rd = 1'b0;
        check("R7 set wins", cts_flag, 1'b1);
        cts_in = 1'b0; tick(4); clear_flag(); irq_en = 1'b0;
    endtask

    task automatic t_remap();
        pin_remap = 1'b1; tick(1);
        cts_in = 1'b1; tick(4);
        check("R8 cts ignored", tx_permit, 1'b1);
        dsr_in = 1'b1; tick(3);
        check("R8 dsr halts", tx_permit, 1'b0);
        dsr_in = 1'b0; cts_in = 1'b0; tick(3);
        check("R8 dsr release", tx_permit, 1'b1);
        trig_sel = 2'd0; fill_count = 8'd8; sw_rts = 1'b0; tick(1);
        check("R8 dtr carries rts", dtr_out, 1'b1);
        check("R8 rts is sw", rts_out, 1'b0);
        sw_rts = 1'b1; #1;
        check("R8 rts follows sw", rts_out, 1'b1);
        fill_count = 8'd0; sw_rts = 1'b0; tick(1);
        check("R8 dtr reasserted", dtr_out, 1'b0);
        pin_remap = 1'b0; tick(1);
    endtask

    task automatic t_shallow();
        deep_mode = 1'b0; trig_sel = 2'd1;
        fill_count = 8'd15; tick(1); check("R9 sel1 below high", rts_out, 1'b0);
        fill_count = 8'd16; tick(1); check("R9 sel1 at high", rts_out, 1'b1);
        fill_count = 8'd10; tick(1); check("R11 hold negated", rts_out, 1'b1);
        fill_count = 8'd8;  tick(1); check("R9 sel1 above low", rts_out, 1'b1);
        fill_count = 8'd7;  tick(1); check("R9 sel1 at low", rts_out, 1'b0);
        fill_count = 8'd10; tick(1); check("R11 hold asserted", rts_out, 1'b0);
        trig_sel = 2'd3;
        fill_count = 8'd27; tick(1); check("R9 sel3 below high", rts_out, 1'b0);
        fill_count = 8'd28; tick(1); check("R9 sel3 at high", rts_out, 1'b1);
        fill_count = 8'd24; tick(1); check("R9 sel3 above low", rts_out, 1'b1);
        fill_count = 8'd23; tick(1); check("R9 sel3 at low", rts_out, 1'b0);
        trig_sel = 2'd2;
        fill_count = 8'd24; tick(1); check("R9 sel2 at high", rts_out, 1'b1);
        fill_count = 8'd16; tick(1); check("R9 sel2 above low", rts_out, 1'b1);
        fill_count = 8'd15; tick(1); check("R9 sel2 at low", rts_out, 1'b0);
        trig_sel = 2'd0;
        fill_count = 8'd7; tick(1); check("R9 sel0 below high", rts_out, 1'b0);
        fill_count = 8'd8; tick(1); check("R9 sel0 at high", rts_out, 1'b1);
        fill_count = 8'd1; tick(1); check("R9 sel0 above low", rts_out, 1'b1);
        fill_count = 8'd0; tick(1); check("R9 sel0 at low", rts_out, 1'b0);
    endtask

    task automatic t_deep();
        deep_mode = 1'b1; flow_hi = 8'd100; flow_lo = 8'd40;
        fill_count = 8'd99;  tick(1); check("R10 below high", rts_out, 1'b0);
        fill_count = 8'd100; tick(1); check("R10 at high", rts_out, 1'b1);
        fill_count = 8'd41;  tick(1); check("R10 above low", rts_out, 1'b1);
        fill_count = 8'd40;  tick(1); check("R10 at low", rts_out, 1'b0);
        flow_hi = 8'd128;
        fill_count = 8'd127; tick(1); check("R10 full below", rts_out, 1'b0);
        fill_count = 8'd128; tick(1); check("R10 full at 128", rts_out, 1'b1);
        fill_count = 8'd0; tick(1); deep_mode = 1'b0;
    endtask

    task automatic t_sw_rts();
        auto_rts_en = 1'b0; fill_count = 8'd30; sw_rts = 1'b0; sw_dtr = 1'b1; tick(2);
        check("R12 rts low", rts_out, 1'b0);
        check("R12 dtr", dtr_out, 1'b1);
        sw_rts = 1'b1; sw_dtr = 1'b0; #1;
        check("R12 rts high", rts_out, 1'b1);
        check("R12 dtr low", dtr_out, 1'b0);
        auto_rts_en = 1'b1; fill_count = 8'd0; tick(1);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_cts_disabled();
        t_idle_stop_resume();
        t_drain();
        t_irq();
        t_remap();
        t_shallow();
        t_deep();
        t_sw_rts();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule